// File: doc/BRIEF.md
# TMDS Test Pattern Generator

This block produces one 10-bit character per clock for the test path of a serial display link. A 3-bit selector picks where that character comes from. It can be a constant zero, the normal encoded data passed through unchanged, a pseudo-random bit sequence, or a programmable 80-bit pattern. The block registers the selected word once before it reaches the output. Serialization and checking of received data are handled by other blocks.

The pseudo-random source offers four polynomial lengths and three output widths. The pattern source holds eight 10-bit characters and steps through them in a ring. It can keep each character on the output for one to eight cycles. Each source has its own enable. A disabled source outputs zero and returns to its starting state.

Top module: `tpg_top`

## Requirements
- R1: While rst_n is low, tmds_out is 0, the PRBS register is all ones and the pattern sequencer points at character 0 with its hold count at 0.
- R2: When out_sel is 3'b001, tmds_out equals the normal_data value that was present one clock earlier.
- R3: When out_sel is 3'b000, or any value other than 3'b001, 3'b010 or 3'b100, tmds_out is 0 one clock later.
- R4: When out_sel is 3'b010 and prbs_en is 0, tmds_out is 0 one clock later. While prbs_en is 0, the PRBS register is reseeded to all ones, so the first enabled cycle starts the sequence from the seed.
- R5: prbs_mode selects the polynomial: 0 selects x^11+x^9+1, 1 selects x^15+x^14+1, 2 selects x^7+x^6+1 and 3 selects x^31+x^28+1. The register is a 31-bit Fibonacci shift register. Each step computes the new bit as s[L-1]^s[T-1], where L and T are the two exponents of the polynomial, then shifts left and inserts the new bit at s[0]. With prbs_width 3, one cycle performs 10 steps, and the k-th new bit (k=0 first) appears at tmds_out[k].
- R6: prbs_width 1 performs 8 steps and places them on tmds_out[7:0], with tmds_out[9:8] at 0. prbs_width 2 performs 1 step, placed on tmds_out[0], with tmds_out[9:1] at 0.
- R7: prbs_width 0 (idle) with prbs_en at 1 keeps the PRBS register unchanged, and the PRBS word is 0.
- R8: With shift_en at 1, the character at index i is shift_pattern[10*i+9:10*i]. Characters are sent in the order 0, 1, ..., 7, and character 0 follows character 7.
- R9: With shift_repeat = R, each character is output for R+1 consecutive cycles before the next one.
- R10: When out_sel is 3'b100 and shift_en is 0, tmds_out is 0 one clock later. The sequencer restarts at character 0 with a fresh hold count on the first cycle with shift_en at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_sel | input | 3 | Source select: 000 zero, 001 normal, 010 PRBS, 100 pattern |
| prbs_en | input | 1 | PRBS generator enable |
| prbs_mode | input | 2 | Polynomial select |
| prbs_width | input | 2 | 0 idle, 1 eight bits, 2 one bit, 3 ten bits |
| shift_en | input | 1 | Pattern sequencer enable |
| shift_repeat | input | 3 | Each character is held for this value plus one cycles |
| shift_pattern | input | 80 | Eight 10-bit characters, index 0 in the low bits |
| normal_data | input | 10 | Encoded data for pass-through |
| tmds_out | output | 10 | Registered output character |

## Verification
Long runs of 10-bit PRBS in each of the four modes tell the polynomials apart, because a wrong tap or length changes the word within the first few cycles. The 8-bit and 1-bit widths, together with idle phases, show whether the step count per cycle and the zeroing of the upper bits are right. A pattern of eight distinct characters, run at repeat counts 0, 3 and 7 through several wraps, exposes errors in ordering, wrap-around and hold timing. Random switching of the selector, the enables and the fields, with pass-through data changing every cycle, checks the one-cycle latency, the zeroing of unlisted selector codes and the reseed when an enable drops.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   localparam int LFSR_W = 31;

   typedef enum logic [2:0] {
      SEL_ZERO  = 3'b000,
      SEL_NORM  = 3'b001,
      SEL_PRBS  = 3'b010,
      SEL_SHIFT = 3'b100
   } out_sel_e;

   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_8    = 2'd1,
      PW_1    = 2'd2,
      PW_FULL = 2'd3
   } prbs_width_e;

   // feedback bit for the selected polynomial
   function automatic logic prbs_fb(input logic [LFSR_W-1:0] s, input logic [1:0] mode);
      logic b;
      case (mode)
         2'd0:    b = s[10] ^ s[8];
         2'd1:    b = s[14] ^ s[13];
         2'd2:    b = s[6]  ^ s[5];
         default: b = s[30] ^ s[27];
      endcase
      return b;
   endfunction
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs
   import tpg_pkg::*;
#(
   parameter int CHAR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        mode,
   input  logic [1:0]        width,
   output logic [CHAR_W-1:0] word
);
   if (CHAR_W < 8) begin : g_bad_width
      $error("tpg_prbs: CHAR_W must be at least 8");
   end

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_d;
   logic [LFSR_W-1:0] chain [CHAR_W+1];
   logic [CHAR_W-1:0] bits;

   assign chain[0] = state_q;
   for (genvar g = 0; g < CHAR_W; g++) begin : g_step
      assign bits[g]    = prbs_fb(chain[g], mode);
      assign chain[g+1] = {chain[g][LFSR_W-2:0], bits[g]};
   end

   always_comb begin
      word    = '0;
      state_d = state_q;
      if (!en) begin
         state_d = '1;
      end else begin
         case (prbs_width_e'(width))
            PW_8: begin
               word    = {{(CHAR_W-8){1'b0}}, bits[7:0]};
               state_d = chain[8];
            end
            PW_1: begin
               word    = {{(CHAR_W-1){1'b0}}, bits[0]};
               state_d = chain[1];
            end
            PW_FULL: begin
               word    = bits;
               state_d = chain[CHAR_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '1;
      else        state_q <= state_d;
   end

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && width == PW_IDLE) |=> state_q == $past(state_q));

   assert_idle_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && width == PW_IDLE) |-> word == '0);
endmodule

// File: rtl/tpg_shift.sv
module tpg_shift #(
   parameter int CHAR_W    = 10,
   parameter int NUM_CHARS = 8,
   parameter int REP_W     = 3,
   localparam int PAT_W    = CHAR_W * NUM_CHARS,
   localparam int IDX_W    = $clog2(NUM_CHARS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [REP_W-1:0]  repeat_cnt,
   input  logic [PAT_W-1:0]  pattern,
   output logic [CHAR_W-1:0] char_out
);
   if (NUM_CHARS < 2) begin : g_bad_chars
      $error("tpg_shift: NUM_CHARS must be at least 2");
   end

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CHARS - 1);

   logic [CHAR_W-1:0] chars [NUM_CHARS];
   logic [IDX_W-1:0]  idx_q;
   logic [REP_W-1:0]  hold_q;

   for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
      assign chars[g] = pattern[g*CHAR_W +: CHAR_W];
   end

   assign char_out = en ? chars[idx_q] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         hold_q <= '0;
      end else if (!en) begin
         idx_q  <= '0;
         hold_q <= '0;
      end else if (hold_q >= repeat_cnt) begin
         hold_q <= '0;
         idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end else begin
         hold_q <= hold_q + 1'b1;
      end
   end

   assert_hold_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hold_q < repeat_cnt) |=> idx_q == $past(idx_q));

   assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hold_q >= repeat_cnt && idx_q == LAST) |=> idx_q == '0);
endmodule

// File: rtl/tpg_top.sv
module tpg_top
   import tpg_pkg::*;
#(
   parameter int CHAR_W    = 10,
   parameter int NUM_CHARS = 8,
   parameter int REP_W     = 3,
   localparam int PAT_W    = CHAR_W * NUM_CHARS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        out_sel,
   input  logic              prbs_en,
   input  logic [1:0]        prbs_mode,
   input  logic [1:0]        prbs_width,
   input  logic              shift_en,
   input  logic [REP_W-1:0]  shift_repeat,
   input  logic [PAT_W-1:0]  shift_pattern,
   input  logic [CHAR_W-1:0] normal_data,
   output logic [CHAR_W-1:0] tmds_out
);
   logic [CHAR_W-1:0] prbs_word;
   logic [CHAR_W-1:0] shift_char;
   logic [CHAR_W-1:0] mux_d;

   tpg_prbs #(.CHAR_W(CHAR_W)) prbs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (prbs_en),
      .mode  (prbs_mode),
      .width (prbs_width),
      .word  (prbs_word)
   );

   tpg_shift #(.CHAR_W(CHAR_W), .NUM_CHARS(NUM_CHARS), .REP_W(REP_W)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (shift_en),
      .repeat_cnt (shift_repeat),
      .pattern    (shift_pattern),
      .char_out   (shift_char)
   );

   always_comb begin
      case (out_sel)
         SEL_NORM:  mux_d = normal_data;
         SEL_PRBS:  mux_d = prbs_word;
         SEL_SHIFT: mux_d = shift_char;
         default:   mux_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmds_out <= '0;
      else        tmds_out <= mux_d;
   end

   assert_pass_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == SEL_NORM) |=> tmds_out == $past(normal_data));

   assert_zero_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_sel inside {SEL_NORM, SEL_PRBS, SEL_SHIFT}) |=> tmds_out == '0);

   assert_prbs_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == SEL_PRBS && !prbs_en) |=> tmds_out == '0);

   assert_byte_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == SEL_PRBS && prbs_width == PW_8) |=> tmds_out[CHAR_W-1:8] == '0);

   assert_bit_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == SEL_PRBS && prbs_width == PW_1) |=> tmds_out[CHAR_W-1:1] == '0);

   assert_shift_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel == SEL_SHIFT && !shift_en) |=> tmds_out == '0);
endmodule

// File: tb/tpg_top_tb_top.sv
`timescale 1ns/1ps
module tpg_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  out_sel = 3'b000;
   logic        prbs_en = 1'b0;
   logic [1:0]  prbs_mode = 2'd0;
   logic [1:0]  prbs_width = 2'd0;
   logic        shift_en = 1'b0;
   logic [2:0]  shift_repeat = 3'd0;
   logic [79:0] shift_pattern = '0;
   logic [9:0]  normal_data = '0;
   logic [9:0]  tmds_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   // bench model state
   logic [30:0] m_prbs = '1;
   int          m_idx = 0;
   int          m_hold = 0;
   logic [9:0]  m_exp = '0;

   always #4 clk = ~clk;

   tpg_top dut_i (
      .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .prbs_en(prbs_en),
      .prbs_mode(prbs_mode), .prbs_width(prbs_width), .shift_en(shift_en),
      .shift_repeat(shift_repeat), .shift_pattern(shift_pattern),
      .normal_data(normal_data), .tmds_out(tmds_out)
   );

   function automatic void poly(input logic [1:0] mode, output int l, output int t);
      case (mode)
         2'd0: begin l = 11; t = 9;  end
         2'd1: begin l = 15; t = 14; end
         2'd2: begin l = 7;  t = 6;  end
         default: begin l = 31; t = 28; end
      endcase
   endfunction

   // advances the model register n steps, returns the new bits in order
   function automatic logic [9:0] run_prbs(inout logic [30:0] s, input logic [1:0] mode, input int n);
      logic [9:0] w = '0;
      int l, t;
      poly(mode, l, t);
      for (int k = 0; k < n; k++) begin
         logic nb;
         nb = s[l-1] ^ s[t-1];
         w[k] = nb;
         s = {s[29:0], nb};
      end
      return w;
   endfunction

   // computes the expected output for the current inputs and updates the model
   task automatic predict();
      logic [9:0] pw = '0;
      logic [9:0] sc = '0;
      if (!prbs_en) m_prbs = '1;
      else begin
         case (prbs_width)
            2'd1: pw = run_prbs(m_prbs, prbs_mode, 8);
            2'd2: pw = run_prbs(m_prbs, prbs_mode, 1);
            2'd3: pw = run_prbs(m_prbs, prbs_mode, 10);
            default: pw = '0;
         endcase
      end
      if (!shift_en) begin
         m_idx = 0; m_hold = 0;
      end else begin
         sc = shift_pattern[m_idx*10 +: 10];
         if (m_hold >= int'(shift_repeat)) begin
            m_hold = 0;
            m_idx = (m_idx == 7) ? 0 : m_idx + 1;
         end else m_hold++;
      end
      case (out_sel)
         3'b001: m_exp = normal_data;
         3'b010: m_exp = pw;
         3'b100: m_exp = sc;
         default: m_exp = '0;
      endcase
   endtask

   function automatic string auto_tag();
      case (out_sel)
         3'b001: return "R2";
         3'b010: begin
            if (!prbs_en) return "R4";
            if (prbs_width == 2'd0) return "R7";
            if (prbs_width == 2'd3) return "R5";
            return "R6";
         end
         3'b100: begin
            if (!shift_en) return "R10";
            if (shift_repeat != 3'd0) return "R9";
            return "R8";
         end
         default: return "R3";
      endcase
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s tmds_out actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   // call at a negedge with inputs set; checks the output one edge later
   task automatic cyc(input string tag = "");
      string t;
      t = (tag == "") ? auto_tag() : tag;
      predict();
      @(posedge clk);
      @(negedge clk);
      check(t, tmds_out, m_exp);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) cycles++;

   initial begin
      wait (cycles > 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", tmds_out, 10'd0);
      normal_data = 10'h3ff;
      out_sel = 3'b001;
      @(negedge clk);
      check("R1", tmds_out, 10'd0);
      rst_n = 1'b1;
      m_prbs = '1; m_idx = 0; m_hold = 0;

      // R1: first enabled PRBS word after reset comes from the all-ones seed
      out_sel = 3'b010; prbs_en = 1'b1; prbs_mode = 2'd2; prbs_width = 2'd3;
      cyc("R1");

      // R5: each polynomial, 10-bit output, starting from a reseed
      for (int m = 0; m < 4; m++) begin
         prbs_en = 1'b0; cyc("R4");
         prbs_en = 1'b1; prbs_mode = 2'(m);
         for (int i = 0; i < 40; i++) cyc("R5");
      end
      // R6 and R7: the narrow widths and idle
      for (int w = 0; w < 3; w++) begin
         prbs_width = 2'(w);
         for (int i = 0; i < 20; i++) cyc(w == 0 ? "R7" : "R6");
      end
      prbs_width = 2'd3; cyc("R7");

      // R3: zero and unlisted selector codes
      normal_data = 10'h155;
      foreach (out_sel[i]) ;
      for (int s = 0; s < 8; s++) begin
         if (s == 1 || s == 2 || s == 4) continue;
         out_sel = 3'(s);
         cyc("R3");
      end

      // R8, R9, R10: distinct characters at several repeat counts
      shift_pattern = '0;
      for (int c = 0; c < 8; c++) shift_pattern[c*10 +: 10] = 10'(10'h040 + c * 10'h05b);
      out_sel = 3'b100;
      shift_en = 1'b0; cyc("R10");
      foreach (shift_pattern[i]) ;
      for (int r = 0; r < 8; r += 3) begin
         shift_repeat = 3'(r);
         shift_en = 1'b0; cyc("R10");
         shift_en = 1'b1;
         for (int i = 0; i < 8 * (r + 1) * 2 + 3; i++) cyc(r == 0 ? "R8" : "R9");
      end
      shift_repeat = 3'd7;
      for (int i = 0; i < 70; i++) cyc("R9");

      // R2: pass-through with changing data
      out_sel = 3'b001;
      for (int i = 0; i < 20; i++) begin
         normal_data = 10'($urandom);
         cyc("R2");
      end

      // random mix
      for (int i = 0; i < 4000; i++) begin
         normal_data = 10'($urandom);
         if ($urandom % 100 < 6) begin
            case ($urandom % 6)
               0: out_sel = 3'b000;
               1: out_sel = 3'b001;
               2, 3: out_sel = 3'b010;
               4: out_sel = 3'b100;
               default: out_sel = 3'($urandom);
            endcase
         end
         if ($urandom % 100 < 3) prbs_en = ~prbs_en;
         if ($urandom % 100 < 3) prbs_mode = 2'($urandom);
         if ($urandom % 100 < 3) prbs_width = 2'($urandom);
         if ($urandom % 100 < 3) shift_en = ~shift_en;
         if ($urandom % 100 < 4) shift_repeat = 3'($urandom);
         if ($urandom % 100 < 1) shift_pattern = {$urandom, $urandom, $urandom};
         cyc();
      end

      done = 1;
      summary();
   end
endmodule